// File: doc/BRIEF.md
# Chroma 4:2:2 to 4:4:4 Upsampler

This block takes a YCbCr 4:2:2 pixel stream and turns it into a 4:4:4 stream in which every output pixel carries its own luma and both chroma components. On the input, each clock brings one luma sample and one chroma sample. The chroma sample alternates between Cb and Cr. The even pixel of each pair brings Cb, and the odd pixel brings the Cr that belongs to the same pair. Pair alignment is taken from the data enable: the pixel on which DE rises is always pixel 0 of a pair.

Chroma for odd pixels is rebuilt in one of two ways, chosen at run time. In repetition mode the odd pixel copies the chroma of its pair. In interpolation mode it takes the rounded mean of its own pair and the next pair. If the next pair is not complete inside the same DE run, the odd pixel falls back to repetition. A separate enable turns the conversion off. The stream is then forwarded with the same latency, and the incoming chroma sample is placed on both chroma outputs. This is the pass-through case used when the input is not 4:2:2 or the output is not 4:4:4. Luma, DE and the syncs are delayed so that they stay aligned with the reconstructed chroma.

Top module: `chroma_upsampler`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: y_o, de_o, hs_o and vs_o equal the y_i, de_i, hs_i and vs_i sampled three rising edges earlier. The output changes after the third edge.
- R3: The pixel position counts from 0 at every rising edge of de_i. Even positions carry Cb on c_i and odd positions carry Cr.
- R4: With active_i high, an even pixel inside DE gives cb_o equal to its own c_i and cr_o equal to the c_i of the following pixel.
- R5: With active_i high and interp_en_i low (repetition, the zero state), an odd pixel gives the same cb_o and cr_o as the even pixel before it.
- R6: With active_i and interp_en_i high, an odd pixel whose next two pixels are still inside DE gives cb_o = (Cb_this_pair + Cb_next_pair + 1) >> 1 and cr_o = (Cr_this_pair + Cr_next_pair + 1) >> 1, computed without overflow at full scale.
- R7: In interpolation mode, an odd pixel whose next pair is not complete inside DE (the last odd pixel of a line) uses repetition as in R5.
- R8: With active_i low, cb_o and cr_o both equal the c_i of the same pixel.
- R9: For a pixel with de_i low, cb_o and cr_o both equal that pixel's c_i, whatever the mode.
- R10: active_i and interp_en_i act on the output registered at the edge two cycles after the pixel's own input edge. The mode can therefore change on any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | 1 | 1: convert 4:2:2 to 4:4:4, 0: forward the stream |
| interp_en_i | input | 1 | 0: chroma repetition, 1: linear interpolation |
| y_i | input | DATA_W | Luma sample |
| c_i | input | DATA_W | Chroma sample, alternating Cb and Cr |
| de_i | input | 1 | Data enable |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| y_o | output | DATA_W | Delayed luma |
| cb_o | output | DATA_W | Blue-difference chroma |
| cr_o | output | DATA_W | Red-difference chroma |
| de_o | output | 1 | Delayed data enable |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |

## Verification
The stimulus uses DE runs of 2, 4, 8, 16 and 20 pixels with random samples. Short runs separate the last-odd-pixel fallback from true interpolation. Longer runs catch phase drift across many pairs. Each run is repeated in repetition mode, interpolation mode and pass-through, so that a swapped Cb and Cr or a wrong neighbour shows up as a mismatch against a different sample. A run held at full-scale chroma exposes a lost carry in the rounded mean. Toggling the mode on every clock inside a line checks on which edge the mode takes effect.

// File: rtl/upsamp_pkg.sv
package upsamp_pkg;
  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;

  typedef struct packed {
    phase_e ph;
    logic   de;
    logic   hs;
    logic   vs;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
endpackage

// File: rtl/upsamp_phase.sv
module upsamp_phase
  import upsamp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   de_i,
  output phase_e ph_o
);
  logic   de_q;
  phase_e ph_q;

  always_comb begin
    if (de_i && !de_q) ph_o = PH_EVEN;
    else               ph_o = (ph_q == PH_EVEN) ? PH_ODD : PH_EVEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q <= 1'b0;
      ph_q <= PH_ODD;
    end else begin
      de_q <= de_i;
      if (de_i) ph_q <= ph_o;
    end
  end
endmodule

// File: rtl/upsamp_dline.sv
module upsamp_dline #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W-1:0]              d_i,
  output logic [DEPTH-1:0][W-1:0]   taps_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taps_o <= '0;
    end else begin
      taps_o[0] <= d_i;
      for (int i = 1; i < int'(DEPTH); i++) taps_o[i] <= taps_o[i-1];
    end
  end
endmodule

// File: rtl/upsamp_recon.sv
module upsamp_recon
  import upsamp_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         active_i,
  input  logic         interp_i,
  input  phase_e       ph_ctr_i,
  input  logic         de_ctr_i,
  input  logic         de_n1_i,
  input  logic         de_n2_i,
  input  logic [W-1:0] c_prev_i,
  input  logic [W-1:0] c_ctr_i,
  input  logic [W-1:0] c_n1_i,
  input  logic [W-1:0] c_n2_i,
  output logic [W-1:0] cb_o,
  output logic [W-1:0] cr_o
);
  localparam int unsigned SW = W + 1;

  logic [SW-1:0] sum_b, sum_r;
  logic [W-1:0]  avg_b, avg_r;
  logic          next_pair_ok;

  // one extra bit keeps the carry at full scale
  assign sum_b = {1'b0, c_prev_i} + {1'b0, c_n1_i} + SW'(1);
  assign sum_r = {1'b0, c_ctr_i}  + {1'b0, c_n2_i} + SW'(1);
  assign avg_b = sum_b[SW-1:1];
  assign avg_r = sum_r[SW-1:1];
  assign next_pair_ok = de_n1_i && de_n2_i;

  always_comb begin
    if (!active_i || !de_ctr_i) begin
      cb_o = c_ctr_i;
      cr_o = c_ctr_i;
    end else if (ph_ctr_i == PH_EVEN) begin
      cb_o = c_ctr_i;
      cr_o = c_n1_i;
    end else if (interp_i && next_pair_ok) begin
      cb_o = avg_b;
      cr_o = avg_r;
    end else begin
      cb_o = c_prev_i;
      cr_o = c_ctr_i;
    end
  end
endmodule

// File: rtl/chroma_upsampler.sv
module chroma_upsampler
  import upsamp_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              interp_en_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic              de_i,
  input  logic              hs_i,
  input  logic              vs_i,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] cr_o,
  output logic              de_o,
  output logic              hs_o,
  output logic              vs_o
);
  localparam int unsigned C_TAPS   = 3;            // prev, centre, next
  localparam int unsigned CTR      = 1;            // centre tap index
  localparam int unsigned CTL_TAPS = CTR + 1;

  phase_e                            ph_in;
  ctl_t                              ctl_in, ctl_ctr, ctl_n1;
  logic [C_TAPS-1:0][DATA_W-1:0]     c_taps;
  logic [CTL_TAPS-1:0][DATA_W-1:0]   y_taps;
  logic [CTL_TAPS-1:0][CTL_W-1:0]    ctl_taps;
  logic [DATA_W-1:0]                 cb_d, cr_d;

  upsamp_phase u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .de_i  (de_i),
    .ph_o  (ph_in)
  );

  assign ctl_in = '{ph: ph_in, de: de_i, hs: hs_i, vs: vs_i};

  upsamp_dline #(.W(DATA_W), .DEPTH(C_TAPS)) u_c_dl (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(c_i), .taps_o(c_taps)
  );

  upsamp_dline #(.W(DATA_W), .DEPTH(CTL_TAPS)) u_y_dl (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(y_i), .taps_o(y_taps)
  );

  upsamp_dline #(.W(CTL_W), .DEPTH(CTL_TAPS)) u_ctl_dl (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(ctl_in), .taps_o(ctl_taps)
  );

  assign ctl_ctr = ctl_t'(ctl_taps[CTR]);
  assign ctl_n1  = ctl_t'(ctl_taps[CTR-1]);

  upsamp_recon #(.W(DATA_W)) u_recon (
    .active_i(active_i),
    .interp_i(interp_en_i),
    .ph_ctr_i(ctl_ctr.ph),
    .de_ctr_i(ctl_ctr.de),
    .de_n1_i (ctl_n1.de),
    .de_n2_i (de_i),
    .c_prev_i(c_taps[CTR+1]),
    .c_ctr_i (c_taps[CTR]),
    .c_n1_i  (c_taps[CTR-1]),
    .c_n2_i  (c_i),
    .cb_o    (cb_d),
    .cr_o    (cr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o  <= '0;
      cb_o <= '0;
      cr_o <= '0;
      de_o <= 1'b0;
      hs_o <= 1'b0;
      vs_o <= 1'b0;
    end else begin
      y_o  <= y_taps[CTR];
      cb_o <= cb_d;
      cr_o <= cr_d;
      de_o <= ctl_ctr.de;
      hs_o <= ctl_ctr.hs;
      vs_o <= ctl_ctr.vs;
    end
  end
endmodule

// File: rtl/chroma_upsampler_chk.sv
module chroma_upsampler_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              active_i,
  input logic [DATA_W-1:0] y_i,
  input logic [DATA_W-1:0] c_i,
  input logic              de_i,
  input logic              hs_i,
  input logic              vs_i,
  input logic [DATA_W-1:0] y_o,
  input logic [DATA_W-1:0] cb_o,
  input logic [DATA_W-1:0] cr_o,
  input logic              de_o,
  input logic              hs_o,
  input logic              vs_o
);
  logic [1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             edges_q <= '0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (y_o == '0 && cb_o == '0 && cr_o == '0 && !de_o && !hs_o && !vs_o));

  assert_luma_de_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q == 2'd3) |=> (y_o == $past(y_i, 3) && de_o == $past(de_i, 3)));

  assert_sync_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q == 2'd3) |=> (hs_o == $past(hs_i, 3) && vs_o == $past(vs_i, 3)));

  assert_bypass_forward_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q == 2'd3 && !active_i) |=> (cb_o == cr_o && cb_o == $past(c_i, 3)));

  assert_blank_forward_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q == 2'd3 && !$past(de_i, 2)) |=> (cb_o == cr_o && cb_o == $past(c_i, 3)));
endmodule

bind chroma_upsampler chroma_upsampler_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i),
  .y_i(y_i), .c_i(c_i), .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i),
  .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o)
);

// File: tb/chroma_upsampler_tb_top.sv
module chroma_upsampler_tb_top;
  localparam int W = 12;
  localparam int N = 8192;
  localparam int MAXV = (1 << W) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic active_i = 1'b1, interp_en_i = 1'b0;
  logic [W-1:0] y_i = '0, c_i = '0;
  logic de_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
  logic [W-1:0] y_o, cb_o, cr_o;
  logic de_o, hs_o, vs_o;

  int checks = 0, fails = 0, rec_n = 0;
  int ay[N], ac[N], ade[N], ahs[N], avs[N], aact[N], aitp[N];
  bit force_max = 1'b0;

  always #4 clk_i = ~clk_i;

  chroma_upsampler #(.DATA_W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i), .interp_en_i(interp_en_i),
    .y_i(y_i), .c_i(c_i), .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i),
    .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o)
  );

  // record what the design sees at each edge
  always @(posedge clk_i) begin
    if (rst_ni && rec_n < N) begin
      ay[rec_n] = int'(y_i);   ac[rec_n] = int'(c_i);
      ade[rec_n] = int'(de_i); ahs[rec_n] = int'(hs_i); avs[rec_n] = int'(vs_i);
      aact[rec_n] = int'(active_i); aitp[rec_n] = int'(interp_en_i);
      rec_n++;
    end
  end

  function automatic int gv(ref int a[N], input int k);
    return (k < 0 || k >= N) ? 0 : a[k];
  endfunction

  // reference: output after edge e shows pixel j = e-2, mode taken at edge e
  always @(negedge clk_i) begin
    if (rst_ni && rec_n > 0 && rec_n <= N) begin
      automatic int e = rec_n - 1;
      automatic int j = e - 2;
      automatic int eb, er, pos, k;
      automatic string tag;
      eb = gv(ac, j); er = eb; tag = "R9";
      if (aact[e] == 0) tag = "R8";
      else if (gv(ade, j) != 0) begin
        k = j;
        while (k > 0 && ade[k-1] != 0) k--;  // R3: position from DE rise
        pos = j - k;
        if (pos % 2 == 0) begin
          tag = "R3/R4"; eb = gv(ac, j); er = gv(ac, j + 1);
        end else if (aitp[e] != 0 && gv(ade, j + 1) != 0 && gv(ade, j + 2) != 0) begin
          tag = "R6";
          eb = (gv(ac, j - 1) + gv(ac, j + 1) + 1) / 2;
          er = (gv(ac, j) + gv(ac, j + 2) + 1) / 2;
        end else begin
          tag = (aitp[e] != 0) ? "R7" : "R5";
          eb = gv(ac, j - 1); er = gv(ac, j);
        end
      end
      checks++;
      if (int'(cb_o) != eb || int'(cr_o) != er) begin
        fails++;
        $display("FAIL %s edge %0d: cb/cr = %0d/%0d expected %0d/%0d", tag, e, cb_o, cr_o, eb, er);
      end
      checks++;
      if (int'(y_o) != gv(ay, j) || int'(de_o) != gv(ade, j) ||
          int'(hs_o) != gv(ahs, j) || int'(vs_o) != gv(avs, j)) begin
        fails++;
        $display("FAIL R2 edge %0d: y/de/hs/vs = %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                 e, y_o, de_o, hs_o, vs_o, gv(ay, j), gv(ade, j), gv(ahs, j), gv(avs, j));
      end
    end
  end

  task automatic pix(input bit de, input bit hs, input bit vs);
    @(negedge clk_i);
    de_i = de; hs_i = hs; vs_i = vs;
    y_i = W'($urandom);
    c_i = force_max ? W'(MAXV - ($urandom % 2)) : W'($urandom);
  endtask

  task automatic line(input int len, input int gap, input bit vs);
    for (int i = 0; i < len; i++) pix(1'b1, 1'b0, vs);
    for (int i = 0; i < gap; i++) pix(1'b0, (i < 2), vs);
  endtask

  task automatic frame_set();
    line(8, 4, 1'b1);
    line(16, 5, 1'b0);
    line(2, 3, 1'b0);
    line(4, 4, 1'b0);
    line(20, 6, 1'b0);
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: nonzero inputs while held in reset
    y_i = '1; c_i = '1; de_i = 1'b1; hs_i = 1'b1; vs_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      checks++;
      if (y_o != 0 || cb_o != 0 || cr_o != 0 || de_o || hs_o || vs_o) begin
        fails++;
        $display("FAIL R1: outputs %0d/%0d/%0d/%b%b%b expected all 0", y_o, cb_o, cr_o, de_o, hs_o, vs_o);
      end
    end
    de_i = 1'b0; hs_i = 1'b0; vs_i = 1'b0; y_i = '0; c_i = '0;
    rst_ni = 1'b1;
    pix(1'b0, 1'b0, 1'b0);

    active_i = 1'b1; interp_en_i = 1'b0; frame_set();   // R5
    interp_en_i = 1'b1; frame_set();                     // R6, R7
    active_i = 1'b0; frame_set();                        // R8
    active_i = 1'b1; force_max = 1'b1; line(12, 4, 1'b0); line(6, 4, 1'b0);  // R6 full scale
    force_max = 1'b0;
    // R10: mode toggles on every clock inside a line
    for (int l = 0; l < 4; l++) begin
      for (int i = 0; i < 14; i++) begin
        interp_en_i = $urandom % 2;
        active_i = ($urandom % 5) != 0;
        pix(1'b1, 1'b0, 1'b0);
      end
      for (int i = 0; i < 3; i++) pix(1'b0, (i == 0), 1'b0);
    end
    active_i = 1'b1; interp_en_i = 1'b1;
    // back-to-back lines with a single blank cycle: phase restarts on each DE rise (R3)
    line(6, 1, 1'b0); line(10, 1, 1'b0); line(4, 1, 1'b0);
    for (int i = 0; i < 6; i++) pix(1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule